// File: doc/BRIEF.md
# Flash burst write command sequencer

This block lets software push a burst of up to 256 bytes into an external flash device, one 32-bit word at a time. Software first writes a control word. That word holds a 24-bit starting flash address, a 2-bit operation code and a "go" bit. Software then writes data words into a separate data port. Each data word becomes one request on a simple flash-side port. That request carries the address and the data, and it stays asserted until the flash answers with a one-cycle acknowledge.

The same control word reads back as a status word. It shows:
- the live flash address;
- the go bit, which hardware drops at the end of the command;
- a busy flag;
- a per-word done flag;
- a whole-command done flag;
- a sticky "update finished" flag that only software can clear.

A byte-length register can cut the burst short of the 256-byte ceiling. Operation codes other than the write code are dropped without touching the flash.

Top module: `flash_burst_seq`

## Requirements
- R1: After reset the status word reads 0xC000_0000: both done flags (bit 31 word-done, bit 30 command-done) are 1 and every other bit is 0. No flash request is raised.
- R2: A control write with bit 26 set and bits 25:24 = 01, made while no command is active, starts a command on the next cycle. Bit 26 reads 1, bits 31 and 30 read 0, and bits 23:0 read the written address.
- R3: A control write with bit 26 set and bits 25:24 equal to 00, 10 or 11 is dropped. Bit 26 stays 0, bits 31:30 stay 11, busy stays 0, the address field keeps its previous value and no flash request is made.
- R4: During a command, a data write made while no request is outstanding raises the flash request on the next cycle. The request carries the current address and the written data, and bit 31 reads 0. Request, address and data hold until the acknowledge.
- R5: The acknowledge ends the request on the next cycle, sets bit 31 and advances the address field by 4, wrapping at 24 bits.
- R6: Busy (bit 27) rises with the first flash request of a command. It stays 1 across the gaps between words and falls with the acknowledge of the last word.
- R7: The command ends with the acknowledge that brings the written byte count to the burst limit. At that point bit 26 clears and bit 30 sets. The limit is the length register's value in bytes, rounded up to whole 4-byte words. A length of 0 or a length above 256 means 256.
- R8: Bit 29 sets when a command ends and stays set. A control write with bit 29 = 0 clears it, and a control write with bit 29 = 1 leaves it unchanged.
- R9: Data writes made while no command is active, or while a flash request is outstanding, are ignored: no extra request is made.
- R10: While a command is active, control writes cannot restart or redirect it and length writes are ignored. The command finishes at the address and length it was started with.
- R11: Bit 28 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_data | input | 32 | Control word write value |
| ctl_rd_data | output | 32 | Status word readback |
| len_wr_en | input | 1 | Length register write strobe |
| len_wr_data | input | 9 | Burst length in bytes (0 means maximum) |
| dat_wr_en | input | 1 | Data word write strobe |
| dat_wr_data | input | 32 | Data word to be written to flash |
| fl_req | output | 1 | Flash write request |
| fl_addr | output | 24 | Flash byte address of the request |
| fl_wdata | output | 32 | Flash write data of the request |
| fl_ack | input | 1 | One-cycle acknowledge from the flash side |

## Verification
The assertions check these properties on every cycle:
- request, address and data are held while no acknowledge has arrived;
- the address field steps by 4 after each acknowledge;
- busy covers every request;
- the command-done flag stays low while a command is active;
- the sticky flag is set whenever command-done rises;
- a dropped operation code never starts a command.

Some behaviour only the bench's scenarios can show:
- the exact cycle the burst ends for different length settings (0, a partial word, a value above 256);
- address wrap at 24 bits;
- the software clear rule of the sticky flag;
- writes that must be ignored, which the scoreboard exposes as missing or surplus flash requests.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    localparam int unsigned FBS_ADDR_W = 24;
    localparam int unsigned FBS_CTL_W  = 32;

    // Bit positions inside the control/status word
    localparam int unsigned BIT_GO     = 26;
    localparam int unsigned BIT_BUSY   = 27;
    localparam int unsigned BIT_RSVD   = 28;
    localparam int unsigned BIT_STICKY = 29;
    localparam int unsigned BIT_CDONE  = 30;
    localparam int unsigned BIT_WDONE  = 31;
    localparam int unsigned OP_LSB     = 24;

    typedef enum logic [1:0] {
        OP_RSV_A = 2'b00,
        OP_WRITE = 2'b01,
        OP_RSV_B = 2'b10,
        OP_RSV_C = 2'b11
    } fbs_op_e;

endpackage

// File: rtl/fbs_cmd_decode.sv
module fbs_cmd_decode
    import fbs_pkg::*;
(
    input  logic                 wr_en,
    input  logic [FBS_CTL_W-1:0] wr_word,
    input  logic                 active,
    output logic                 start,
    output logic                 drop,
    output logic                 keep_sticky,
    output logic [1:0]           op,
    output logic [FBS_ADDR_W-1:0] addr
);
    logic issue;
    logic unused_bits;

    assign op          = wr_word[OP_LSB +: 2];
    assign addr        = wr_word[FBS_ADDR_W-1:0];
    assign issue       = wr_en && wr_word[BIT_GO] && !active;
    assign start       = issue && (fbs_op_e'(op) == OP_WRITE);
    assign drop        = issue && (fbs_op_e'(op) != OP_WRITE);
    assign keep_sticky = !wr_en || wr_word[BIT_STICKY];
    assign unused_bits = ^{wr_word[BIT_WDONE], wr_word[BIT_CDONE],
                           wr_word[BIT_RSVD], wr_word[BIT_BUSY]};
endmodule

// File: rtl/fbs_burst_track.sv
module fbs_burst_track #(
    parameter int unsigned MAX_BYTES  = 256,
    parameter int unsigned WORD_BYTES = 4,
    parameter int unsigned LEN_W      = 9,
    parameter int unsigned CNT_W      = 9
) (
    input  logic [LEN_W-1:0] len_q,
    input  logic [CNT_W-1:0] bytes_q,
    output logic             last_word
);
    localparam int unsigned SUM_W = ((LEN_W > CNT_W) ? LEN_W : CNT_W) + 2;

    logic [SUM_W-1:0] len_x;
    logic [SUM_W-1:0] limit;
    logic [SUM_W-1:0] after;

    always_comb begin
        len_x = SUM_W'(len_q);
        if (len_x == '0 || len_x > SUM_W'(MAX_BYTES)) begin
            limit = SUM_W'(MAX_BYTES);
        end else begin
            limit = len_x;
        end
        after     = SUM_W'(bytes_q) + SUM_W'(WORD_BYTES);
        last_word = (after >= limit);
    end
endmodule

// File: rtl/fbs_status_pack.sv
module fbs_status_pack
    import fbs_pkg::*;
(
    input  logic                  go,
    input  logic [1:0]            op,
    input  logic [FBS_ADDR_W-1:0] addr,
    input  logic                  busy,
    input  logic                  sticky,
    input  logic                  cdone,
    input  logic                  wdone,
    output logic [FBS_CTL_W-1:0]  word
);
    always_comb begin
        word                  = '0;
        word[FBS_ADDR_W-1:0]  = addr;
        word[OP_LSB +: 2]     = op;
        word[BIT_GO]          = go;
        word[BIT_BUSY]        = busy;
        word[BIT_RSVD]        = 1'b0;
        word[BIT_STICKY]      = sticky;
        word[BIT_CDONE]       = cdone;
        word[BIT_WDONE]       = wdone;
    end
endmodule

// File: rtl/flash_burst_seq.sv
module flash_burst_seq
    import fbs_pkg::*;
#(
    parameter int unsigned MAX_BYTES  = 256,
    parameter int unsigned WORD_BYTES = 4,
    parameter int unsigned LEN_W      = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ctl_wr_en,
    input  logic [FBS_CTL_W-1:0]          ctl_wr_data,
    output logic [FBS_CTL_W-1:0]          ctl_rd_data,
    input  logic                          len_wr_en,
    input  logic [LEN_W-1:0]              len_wr_data,
    input  logic                          dat_wr_en,
    input  logic [8*WORD_BYTES-1:0]       dat_wr_data,
    output logic                          fl_req,
    output logic [FBS_ADDR_W-1:0]         fl_addr,
    output logic [8*WORD_BYTES-1:0]       fl_wdata,
    input  logic                          fl_ack
);
    localparam int unsigned DATA_W = 8 * WORD_BYTES;
    localparam int unsigned CNT_W  = $clog2(MAX_BYTES + 1);

    typedef struct packed {
        logic                  go;
        logic [1:0]            op;
        logic [FBS_ADDR_W-1:0] addr;
        logic                  busy;
        logic                  sticky;
        logic                  cdone;
        logic                  wdone;
        logic                  req;
        logic [DATA_W-1:0]     wdata;
        logic [CNT_W-1:0]      bytes;
        logic [LEN_W-1:0]      len;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic                  start, drop, keep_sticky, last_word;
    logic [1:0]            dec_op;
    logic [FBS_ADDR_W-1:0] dec_addr;

    fbs_cmd_decode i_decode (
        .wr_en       (ctl_wr_en),
        .wr_word     (ctl_wr_data),
        .active      (s_q.go),
        .start       (start),
        .drop        (drop),
        .keep_sticky (keep_sticky),
        .op          (dec_op),
        .addr        (dec_addr)
    );

    fbs_burst_track #(
        .MAX_BYTES  (MAX_BYTES),
        .WORD_BYTES (WORD_BYTES),
        .LEN_W      (LEN_W),
        .CNT_W      (CNT_W)
    ) i_track (
        .len_q     (s_q.len),
        .bytes_q   (s_q.bytes),
        .last_word (last_word)
    );

    fbs_status_pack i_pack (
        .go     (s_q.go),
        .op     (s_q.op),
        .addr   (s_q.addr),
        .busy   (s_q.busy),
        .sticky (s_q.sticky),
        .cdone  (s_q.cdone),
        .wdone  (s_q.wdone),
        .word   (ctl_rd_data)
    );

    always_comb begin
        s_d = s_q;
        // software clear of the sticky flag (hardware set below wins)
        if (!keep_sticky) begin
            s_d.sticky = 1'b0;
        end
        // command acceptance
        if (start) begin
            s_d.go    = 1'b1;
            s_d.op    = dec_op;
            s_d.addr  = dec_addr;
            s_d.cdone = 1'b0;
            s_d.wdone = 1'b0;
            s_d.bytes = '0;
        end
        // burst length may only change between commands
        if (len_wr_en && !s_q.go) begin
            s_d.len = len_wr_data;
        end
        // data word launches a flash request
        if (dat_wr_en && s_q.go && !s_q.req) begin
            s_d.req   = 1'b1;
            s_d.wdata = dat_wr_data;
            s_d.wdone = 1'b0;
            s_d.busy  = 1'b1;
        end
        // acknowledge retires the word
        if (s_q.req && fl_ack) begin
            s_d.req   = 1'b0;
            s_d.wdone = 1'b1;
            s_d.addr  = s_q.addr + FBS_ADDR_W'(WORD_BYTES);
            s_d.bytes = s_q.bytes + CNT_W'(WORD_BYTES);
            if (last_word) begin
                s_d.go     = 1'b0;
                s_d.cdone  = 1'b1;
                s_d.busy   = 1'b0;
                s_d.sticky = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.cdone  <= 1'b1;
            s_q.wdone  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign fl_req   = s_q.req;
    assign fl_addr  = s_q.addr;
    assign fl_wdata = s_q.wdata;

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_ack) |=> (fl_req && $stable(fl_addr) && $stable(fl_wdata)));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && fl_ack) |=> (!fl_req && ctl_rd_data[BIT_WDONE] &&
            ctl_rd_data[FBS_ADDR_W-1:0] == FBS_ADDR_W'($past(fl_addr) + FBS_ADDR_W'(WORD_BYTES))));

    // R6
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> ctl_rd_data[BIT_BUSY]);

    // R3
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (!ctl_rd_data[BIT_GO] && !fl_req));

    // R7
    done_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd_data[BIT_GO] |-> !ctl_rd_data[BIT_CDONE]);

    // R8
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_rd_data[BIT_CDONE]) |-> ctl_rd_data[BIT_STICKY]);

endmodule

// File: tb/test_flash_burst_seq.sv
module test_flash_burst_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctl_wr_en;
    logic [31:0] ctl_wr_data;
    logic [31:0] ctl_rd_data;
    logic        len_wr_en;
    logic [8:0]  len_wr_data;
    logic        dat_wr_en;
    logic [31:0] dat_wr_data;
    logic        fl_req;
    logic [23:0] fl_addr;
    logic [31:0] fl_wdata;
    logic        fl_ack;

    int n_checks = 0;
    int n_errors = 0;
    int ack_lat  = 2;
    int req_seen = 0;
    logic [55:0] sb_q[$];
    logic [23:0] exp_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_burst_seq i_flash_burst_seq (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
        .len_wr_en(len_wr_en), .len_wr_data(len_wr_data),
        .dat_wr_en(dat_wr_en), .dat_wr_data(dat_wr_data),
        .fl_req(fl_req), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_ack(fl_ack)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    function automatic logic [31:0] go_word(logic [1:0] op, logic [23:0] a);
        return {5'b0, 1'b1, op, a};
    endfunction

    task automatic ctl_write(logic [31:0] v);
        @(negedge clk); ctl_wr_en = 1'b1; ctl_wr_data = v;
        @(negedge clk); ctl_wr_en = 1'b0;
    endtask

    task automatic len_write(logic [8:0] v);
        @(negedge clk); len_wr_en = 1'b1; len_wr_data = v;
        @(negedge clk); len_wr_en = 1'b0;
    endtask

    // driver: pushes the expected flash item when the write should be taken
    task automatic data_write(logic [31:0] d, bit taken);
        if (taken) begin
            sb_q.push_back({exp_addr, d});
            exp_addr = exp_addr + 24'd4;
        end
        @(negedge clk); dat_wr_en = 1'b1; dat_wr_data = d;
        @(negedge clk); dat_wr_en = 1'b0;
    endtask

    task automatic wait_wdone();
        for (int k = 0; k < 50; k++) begin
            if (ctl_rd_data[31]) break;
            @(negedge clk);
        end
    endtask

    // one full burst: nwords words, checks busy/go between words and the end
    task automatic burst(logic [23:0] base, int nwords, int redirect_at);
        ctl_write(go_word(2'b01, base));
        exp_addr = base;
        check("R2", {8'h0, ctl_rd_data[23:0]}, {8'h0, base}, "start address");
        for (int i = 0; i < nwords; i++) begin
            data_write(32'hA5000000 + i, 1'b1);
            wait_wdone();
            check("R5", {8'h0, ctl_rd_data[23:0]}, {8'h0, exp_addr}, "address after word");
            if (i == redirect_at) begin
                // R10: restart attempt and length change are ignored
                ctl_write(go_word(2'b01, 24'h123450));
                len_write(9'd4);
                check("R10", {8'h0, ctl_rd_data[23:0]}, {8'h0, exp_addr}, "address not redirected");
            end
            if (i < nwords - 1) begin
                check("R7", ctl_rd_data[26], 1'b1, "command still active");
                check("R6", ctl_rd_data[27], 1'b1, "busy between words");
            end
        end
        check("R7", ctl_rd_data[26], 1'b0, "command ended");
        check("R7", ctl_rd_data[30], 1'b1, "command done");
        check("R6", ctl_rd_data[27], 1'b0, "busy after last word");
        check("R8", ctl_rd_data[29], 1'b1, "sticky set");
    endtask

    // monitor: pops scoreboard on every request and acknowledges it
    initial begin
        logic [55:0] item;
        fl_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && fl_req) begin
                req_seen++;
                if (sb_q.size() == 0) begin
                    n_checks++; n_errors++;
                    $display("FAIL R9 unexpected request: actual addr=%h expected none", fl_addr);
                end else begin
                    item = sb_q.pop_front();
                    check("R4", {8'h0, fl_addr}, {8'h0, item[55:32]}, "request address");
                    check("R4", fl_wdata, item[31:0], "request data");
                    check("R4", ctl_rd_data[31], 1'b0, "word done low during request");
                end
                repeat (ack_lat) @(negedge clk);
                check("R4", {31'b0, fl_req}, 32'd1, "request held until ack");
                fl_ack = 1'b1;
                @(negedge clk);
                fl_ack = 1'b0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int seen0;
        rst_n = 1'b0; ctl_wr_en = 1'b0; ctl_wr_data = '0;
        len_wr_en = 1'b0; len_wr_data = '0; dat_wr_en = 1'b0; dat_wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", ctl_rd_data, 32'hC000_0000, "reset status");
        check("R1", {31'b0, fl_req}, 32'd0, "no request after reset");

        // first command: 16 bytes, ack latency 2, with an extra write while pending
        ack_lat = 2;
        len_write(9'd16);
        ctl_write(go_word(2'b01, 24'h001000));
        exp_addr = 24'h001000;
        check("R2", ctl_rd_data[31:24], 8'b0000_0101, "flags after start");
        check("R2", {8'h0, ctl_rd_data[23:0]}, 32'h0000_1000, "address after start");
        for (int i = 0; i < 4; i++) begin
            data_write(32'hC0DE0000 + i, 1'b1);
            check("R4", ctl_rd_data[31], 1'b0, "word done cleared by data write");
            check("R6", ctl_rd_data[27], 1'b1, "busy with request");
            if (i == 0) data_write(32'hDEADBEEF, 1'b0);   // R9 pending request
            wait_wdone();
            check("R5", {8'h0, ctl_rd_data[23:0]}, {8'h0, exp_addr}, "address step");
            check("R11", ctl_rd_data[28], 1'b0, "reserved bit");
            if (i < 3) check("R6", ctl_rd_data[27], 1'b1, "busy in gap");
        end
        check("R7", ctl_rd_data[26], 1'b0, "go cleared at end");
        check("R7", ctl_rd_data[30], 1'b1, "command done at end");
        check("R6", ctl_rd_data[27], 1'b0, "busy after last ack");
        check("R8", ctl_rd_data[29], 1'b1, "sticky set at end");

        // R9: data write without an active command
        seen0 = req_seen;
        data_write(32'h11112222, 1'b0);
        repeat (5) @(negedge clk);
        check("R9", req_seen, seen0, "request count idle");

        // R8: writing bit 29 = 1 keeps, bit 29 = 0 clears
        ctl_write(32'h2000_0000);
        check("R8", ctl_rd_data[29], 1'b1, "sticky kept");
        check("R2", ctl_rd_data[26], 1'b0, "no start without go bit");
        ctl_write(32'h0000_0000);
        check("R8", ctl_rd_data[29], 1'b0, "sticky cleared");

        // R3: reserved operation codes
        foreach (sb_q[k]) ;
        for (int c = 0; c < 4; c++) begin
            if (c == 1) continue;
            ctl_write(go_word(c[1:0], 24'hABCDE0));
            check("R3", ctl_rd_data[26], 1'b0, "reserved op not started");
            check("R3", ctl_rd_data[31:30], 2'b11, "done flags kept");
            check("R3", ctl_rd_data[27], 1'b0, "no busy");
            check("R3", {8'h0, ctl_rd_data[23:0]}, 32'h0000_1010, "address kept");
            data_write(32'h33334444, 1'b0);
            repeat (3) @(negedge clk);
        end
        check("R3", req_seen, seen0, "no request for reserved op");

        // R7 + R10: length 0 means 256 bytes, address wraps at 24 bits
        ack_lat = 0;
        len_write(9'd0);
        burst(24'hFFFFF0, 64, 10);
        check("R5", {8'h0, ctl_rd_data[23:0]}, 32'h0000_00F0, "wrapped end address");

        // R7: partial word rounds up (6 bytes -> 2 words)
        ack_lat = 1;
        len_write(9'd6);
        burst(24'h000200, 2, -1);

        // R7: length above 256 is clipped
        ack_lat = 0;
        len_write(9'd300);
        burst(24'h040000, 64, -1);

        repeat (5) @(negedge clk);
        check("R9", sb_q.size(), 0, "scoreboard drained");
        summary();
        $finish;
    end
endmodule